// File: doc/BRIEF.md
# SRAM Bank Power Enable Controller

This block decides which banks of a banked SRAM stay powered. It holds one enable bit for each of up to 64 banks. Software sees these bits as two 32-bit registers on a simple register bus. The enabled banks always form one unbroken run that starts at bank 0. Software may write any pattern. The block keeps only the highest set bit of that pattern and turns it into a thermometer code, so every bank below that bit is switched on and every bank above it is switched off.

The parameter `NUM_BANKS` gives the number of banks that exist. Enables for banks at or above that number are held at 0, and a request for a higher bank is reduced to the top present bank. When an accepted write changes the vector, the ready output goes low for `SETTLE_CYCLES` clocks, which stands in for the time the power switches need. While ready is low, every write is dropped. Reads always return the vector after it has been made legal, never the raw value that was written.

Top module: `sram_bank_gate`

## Requirements
- R1: After reset, `bank_en` has exactly the lowest `NUM_BANKS` bits set and `bank_ready` is 1.
- R2: An accepted write to offset 0x50 (bit i drives bank i) sets `bank_en` to ones in bits 0 through the highest set bit of the write data, and zeros above that bit. This applies even when the old vector reached into banks 32 to 63.
- R3: An accepted write to offset 0x54 (bit i drives bank 32+i) with nonzero data sets ones in bits 0 through 32 plus its highest set bit. With zero data, banks 32 to 63 are cleared and banks 0 to 31 keep their state.
- R4: An accepted write of zero to offset 0x50 leaves only bank 0 enabled.
- R5: No bit of `bank_en` at or above `NUM_BANKS` is ever 1. A request above that limit becomes ones in all `NUM_BANKS` low bits.
- R6: A write while `bank_ready` is 0 has no effect. A write to any offset other than 0x50 or 0x54 has no effect either. Offset 0x54 is also ignored when `NUM_BANKS` is 32 or less.
- R7: When an accepted write changes `bank_en`, `bank_ready` is 0 for the `SETTLE_CYCLES` clocks that follow the write edge and then returns to 1. A write that does not change the vector leaves `bank_ready` at 1.
- R8: `bus_rdata` is combinational from `bus_addr`:
  - 0x50 returns `bank_en[31:0]`.
  - 0x54 returns `bank_en[63:32]`, or 0 when `NUM_BANKS` is 32 or less.
  - Any other offset returns 0.
- R9: `bank_en` always has bank 0 set and contains no 0 below a 1.
- R10: The new vector appears on `bank_en` at the clock edge that samples the write (`bus_sel` and `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| bank_en | output | 64 | Per-bank enable, bit i = bank i |
| bank_ready | output | 1 | 1 when writes are accepted |

## Verification
There are two timing cases.
- **Registered results.** `bank_en` and the end of the settle window come from registers. A write driven on one falling edge shows its vector after the next rising edge. `bank_ready` is then low for exactly `SETTLE_CYCLES` rising edges.
- **Read data.** `bus_rdata` is due in the same cycle that its address is driven.

The bench drives inputs on falling edges. A behavioural reference model steps on every rising edge. One time unit after each falling edge, the bench compares the enable vector, the ready flag and the read data with the model, so each registered result is sampled half a cycle after the edge that produced it. Directed phases cover each requirement. Pseudo-random writes follow them, and some of those writes land inside the settle window.

// File: rtl/sram_bank_gate.sv
module sram_bank_gate #(
  parameter int NUM_BANKS     = 48,
  parameter int SETTLE_CYCLES = 4,
  parameter int ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h50,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [63:0]       bank_en,
  output logic              bank_ready
);

  localparam int         CNT_W   = $clog2(SETTLE_CYCLES + 1);
  localparam logic [6:0] TOP_MAX = 7'(NUM_BANKS - 1);
  localparam bit         HAS_HI  = NUM_BANKS > 32;

  function automatic logic [4:0] top_bit(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [63:0] thermo(input logic [6:0] top);
    logic [63:0] t;
    for (int i = 0; i < 64; i++)
      t[i] = (7'(i) <= top);
    return t;
  endfunction

  logic [63:0]      en_q, nxt_en;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       req_top, lim_top;
  logic             lo_hit, hi_hit, wr_go, changed;

  assign bank_ready = (cnt_q == '0);
  assign bank_en    = en_q;

  assign lo_hit = (bus_addr == LO_OFS);
  assign hi_hit = HAS_HI && (bus_addr == HI_OFS);
  assign wr_go  = bus_sel && bus_wr && bank_ready && (lo_hit || hi_hit);

  assign req_top = lo_hit ? {2'b00, top_bit(bus_wdata)} : {2'b01, top_bit(bus_wdata)};
  assign lim_top = (req_top > TOP_MAX) ? TOP_MAX : req_top;

  always_comb begin
    if (hi_hit && bus_wdata == '0) nxt_en = en_q & 64'h0000_0000_FFFF_FFFF;
    else                           nxt_en = thermo(lim_top);
  end

  assign changed = (nxt_en != en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= thermo(TOP_MAX);
      cnt_q <= '0;
    end else if (wr_go && changed) begin
      en_q  <= nxt_en;
      cnt_q <= CNT_W'(SETTLE_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  generate
    if (HAS_HI) begin : g_rd_hi
      assign bus_rdata = lo_hit ? en_q[31:0] : (hi_hit ? en_q[63:32] : 32'h0);
    end else begin : g_rd_lo
      assign bus_rdata = lo_hit ? en_q[31:0] : 32'h0;
    end
  endgenerate

endmodule

module sram_bank_gate_chk #(
  parameter int NUM_BANKS = 48,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h50,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h54
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [63:0]       bank_en,
  input logic              bank_ready
);
  localparam logic [63:0] CAP = (NUM_BANKS >= 64) ? '1 : ((64'd1 << NUM_BANKS) - 64'd1);

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (bank_ready && bank_en == CAP));

  // R9
  thermo_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_en[0] && (((bank_en + 64'd1) & bank_en) == 64'd0));

  // R5
  bank_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) (bank_en & ~CAP) == 64'd0);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ready |=> $stable(bank_en));

  // R7
  settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en != $past(bank_en)) |-> !bank_ready);

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(bank_en));

  // R8
  stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != LO_OFS && bus_addr != HI_OFS) |-> bus_rdata == 32'h0);
endmodule

bind sram_bank_gate sram_bank_gate_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bank_en(bank_en), .bank_ready(bank_ready)
);

// File: tb/sim_sram_bank_gate.sv
`timescale 1ns/100ps
module sim_sram_bank_gate;
  localparam int NB = 48;
  localparam int SC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h50;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] bank_en;
  logic        bank_ready;

  always #2.5 clk = ~clk;

  sram_bank_gate #(.NUM_BANKS(NB), .SETTLE_CYCLES(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_en(bank_en), .bank_ready(bank_ready));

  int n_vec = 0, n_bad = 0;
  string phase = "R1";
  int m_top;
  int m_cnt;
  bit run_cmp = 0;

  function automatic logic [63:0] ones(input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_top = NB - 1; m_cnt = 0;
    end else begin
      int want;
      bit acc;
      acc = bus_sel && bus_wr && m_cnt == 0 &&
            (bus_addr == 8'h50 || (bus_addr == 8'h54 && NB > 32));
      want = m_top;
      if (acc) begin
        if (bus_addr == 8'h50) begin
          want = 0;
          for (int i = 0; i < 32; i++) if (bus_wdata[i]) want = i;
        end else if (bus_wdata == 0) begin
          want = (m_top > 31) ? 31 : m_top;
        end else begin
          for (int i = 0; i < 32; i++) if (bus_wdata[i]) want = 32 + i;
        end
        if (want > NB - 1) want = NB - 1;
      end
      if (acc && want != m_top) begin
        m_top = want; m_cnt = SC;
      end else if (m_cnt > 0) m_cnt--;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      logic [63:0] me;
      logic [31:0] rd;
      #1;
      me = ones(m_top + 1);
      chk({phase, " bank_en"}, bank_en, me);
      chk({phase, " bank_ready"}, {63'd0, bank_ready}, {63'd0, m_cnt == 0});
      rd = (bus_addr == 8'h50) ? me[31:0] : (bus_addr == 8'h54 ? me[63:32] : 32'h0);
      chk({phase, " R8 rdata"}, {32'd0, bus_rdata}, {32'd0, rd});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_addr = a;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_cmp = 1;
    phase = "R1";
    #1;
    chk("R1 reset bank_en", bank_en, ones(NB));
    chk("R1 reset ready", {63'd0, bank_ready}, 64'd1);
    idle(2, 8'h54);
    phase = "R2"; wr(8'h50, 32'h0000_0100); #1;
    chk("R2 low write top 8", bank_en, ones(9));
    chk("R7 ready low after change", {63'd0, bank_ready}, 64'd0);
    phase = "R6"; wr(8'h50, 32'h0000_0001); #1;
    chk("R6 write while busy ignored", bank_en, ones(9));
    phase = "R7"; idle(SC + 1, 8'h50);
    phase = "R4"; wr(8'h50, 32'h0); #1;
    chk("R4 zero write keeps bank 0", bank_en, 64'd1);
    idle(SC + 1, 8'h50);
    phase = "R5"; wr(8'h54, 32'h8000_0000); #1;
    chk("R5 capped to NUM_BANKS", bank_en, ones(NB));
    idle(SC + 1, 8'h54);
    phase = "R3"; wr(8'h54, 32'h0000_0004); #1;
    chk("R3 upper write top 34", bank_en, ones(35));
    idle(SC + 1, 8'h54);
    wr(8'h54, 32'h0); #1;
    chk("R3 upper zero keeps low 32", bank_en, ones(32));
    idle(SC + 1, 8'h50);
    phase = "R7"; wr(8'h50, 32'hFFFF_FFFF); #1;
    chk("R7 unchanged write keeps ready", {63'd0, bank_ready}, 64'd1);
    phase = "R2"; wr(8'h54, 32'h0000_0200); idle(SC + 1, 8'h50);
    wr(8'h50, 32'h0000_0010); #1;
    chk("R2 low write clears upper banks", bank_en, ones(5));
    idle(SC + 1, 8'h58);
    phase = "R6"; wr(8'h58, 32'hFFFF_FFFF); #1;
    chk("R6 stray offset write ignored", bank_en, ones(5));
    chk("R8 stray offset reads 0", {32'd0, bus_rdata}, 64'd0);
    phase = "R10";
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d;
      d = $urandom >> ($urandom % 32);
      wr(($urandom % 3 == 0) ? 8'h54 : 8'h50, d);
      idle($urandom % (SC + 2), ($urandom % 2) ? 8'h50 : 8'h54);
    end
    run_cmp = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule